// File: doc/BRIEF.md
# Four-Port Shared Byte Memory

A 4096-word by 8-bit storage array with four identical, fully independent ports. Each port has its own address, write data, and active-low select, write and output-enable controls. No port has priority over the others, and there is no arbitration or wait signalling. A port can read or write any word in every cycle, and all four ports can run at once.

The model is clocked. A write takes effect at a rising clock edge. A read returns the addressed byte one cycle after it is requested, together with a per-port valid flag. This flag stands in for a tri-state driver being turned on. The block reports standby for each deselected port, and full standby when no port is selected.

If two or more ports write one word in the same cycle, the block raises a one-cycle collision flag and a mask of the ports involved. It resolves the write by storing the data of the lowest-numbered port involved, so the result is always defined.

Top module: `quad_port_ram`

## Requirements
- R1: The array has 4096 words of 8 bits. Port p uses address bits `addr[p*12 +: 12]`, write-data bits `wdata[p*8 +: 8]` and read-data bits `rdata[p*8 +: 8]`. Every address from 0x000 to 0xFFF can be written and read back.
- R2: A port with `cs_n[p]`=1 is deselected, whatever its `we_n[p]` and `oe_n[p]` are. In the next cycle it has `rvalid[p]`=0 and a zero byte on `rdata`, and it changes no memory word.
- R3: A port stores its write-data byte at the addressed word on a rising edge where `cs_n[p]`=0 and `we_n[p]`=0.
- R4: In a cycle where a port writes, its `rvalid[p]` is 0 in the next cycle, even when `oe_n[p]`=0.
- R5: A port with `cs_n`=0, `we_n`=1 and `oe_n`=0 sees `rvalid`=1 and the stored byte on `rdata` in the next cycle. With `oe_n`=1 instead, it sees `rvalid`=0 and a zero byte.
- R6: All four ports can read the same word in the same cycle, and each receives that word's stored byte.
- R7: A byte written through one port can be read through every other port from the next cycle on.
- R8: `standby[p]` follows `cs_n[p]` with no clock delay. `all_standby` is 1 only while all four `cs_n` bits are 1.
- R9: When two or more ports write the same word in one cycle, the next cycle has `coll`=1, and `coll_mask` bit p is set for each port involved and for no other port. The word keeps the lowest-numbered writer's byte. The flag and the mask drop in the following cycle unless another collision occurs.
- R10: A read of a word that another port writes in the same cycle returns the old contents. The new byte is returned from the next cycle on.
- R11: While `rst_n` is 0, `rvalid`, `rdata`, `coll` and `coll_mask` are all zero. The memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 4 | Per-port select, active low |
| we_n | input | 4 | Per-port write strobe, active low |
| oe_n | input | 4 | Per-port output enable, active low |
| addr | input | 48 | Four 12-bit word addresses, port p at bits p*12 and up |
| wdata | input | 32 | Four write bytes, port p at bits p*8 and up |
| rdata | output | 32 | Four registered read bytes, zero when not valid |
| rvalid | output | 4 | Per-port read data valid (output driver on) |
| standby | output | 4 | Per-port deselected status |
| all_standby | output | 1 | All four ports deselected |
| coll | output | 1 | Same-word write collision in the previous cycle |
| coll_mask | output | 4 | Ports involved in that collision |

## Verification
The first stimulus is a single-port write followed by a read-back on the same port, which shows whether storage works at all. Four-port writes to distinct words that include both ends of the address range follow, then reads rotated across the ports. Together these separate a correct slicing of the address and data buses from a port-to-port mix-up. Next come four readers on a single word, and a write that overlaps a read of the same word, which tell simultaneous reads apart and show read-before-write ordering. A three-port same-word write with a fourth, separate writer checks that the mask names exactly the colliding ports and that the lowest-numbered port wins. Deselected writes and reads with the output disabled check that those control states really suppress the write or the data.

// File: rtl/quad_port_ram.sv
module quad_port_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           cs_n,
  input  logic [3:0]           we_n,
  input  logic [3:0]           oe_n,
  input  logic [4*ADDR_W-1:0]  addr,
  input  logic [4*DATA_W-1:0]  wdata,
  output logic [4*DATA_W-1:0]  rdata,
  output logic [3:0]           rvalid,
  output logic [3:0]           standby,
  output logic                 all_standby,
  output logic                 coll,
  output logic [3:0]           coll_mask
);
  localparam int NP    = 4;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] a [NP];
  logic [DATA_W-1:0] d [NP];
  logic [NP-1:0]     wr_en, rd_en, clash;

  for (genvar p = 0; p < NP; p++) begin : g_slice
    assign a[p] = addr[p*ADDR_W +: ADDR_W];
    assign d[p] = wdata[p*DATA_W +: DATA_W];
  end

  assign wr_en       = ~cs_n & ~we_n;
  assign rd_en       = ~cs_n & we_n & ~oe_n;
  assign standby     = cs_n;
  assign all_standby = &cs_n;
  assign coll        = |coll_mask;

  always_comb begin
    clash = '0;
    for (int i = 0; i < NP; i++)
      for (int j = 0; j < NP; j++)
        if (i != j && wr_en[i] && wr_en[j] && a[i] == a[j])
          clash[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = NP - 1; i >= 0; i--)
      if (wr_en[i]) mem[a[i]] <= d[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      rvalid    <= '0;
      coll_mask <= '0;
    end else begin
      for (int i = 0; i < NP; i++)
        rdata[i*DATA_W +: DATA_W] <= rd_en[i] ? mem[a[i]] : '0;
      rvalid    <= rd_en;
      coll_mask <= clash;
    end
  end
endmodule

// File: rtl/quad_port_ram_chk.sv
module quad_port_ram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cs_n,
  input logic [3:0] we_n,
  input logic [3:0] oe_n,
  input logic [3:0] rvalid,
  input logic [3:0] standby,
  input logic       all_standby,
  input logic [3:0] coll_mask
);
  for (genvar p = 0; p < 4; p++) begin : g_port
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n[p] |=> !rvalid[p]); // R2
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n[p] && !we_n[p]) |=> !rvalid[p]); // R4
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n[p] && we_n[p] && !oe_n[p]) |=> rvalid[p]); // R5
    AST_COLL_IS_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n[p] && we_n[p]) |=> !coll_mask[p]); // R9
  end

  AST_MASK_NOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(coll_mask) != 1); // R9
  AST_ALL_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    all_standby |-> (standby == 4'hF)); // R8
endmodule

bind quad_port_ram quad_port_ram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
  .rvalid(rvalid), .standby(standby), .all_standby(all_standby),
  .coll_mask(coll_mask)
);

// File: tb/quad_port_ram_test.sv
module quad_port_ram_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cs_n, we_n, oe_n;
  logic [47:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  rvalid, standby, coll_mask;
  logic        all_standby, coll;

  int checks = 0;
  int failures = 0;
  logic [7:0] ref_mem [int];

  always #10 clk = ~clk;

  quad_port_ram uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .standby(standby), .all_standby(all_standby), .coll(coll),
    .coll_mask(coll_mask)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_all();
    cs_n = 4'hF; we_n = 4'hF; oe_n = 4'hF; addr = '0; wdata = '0;
  endtask

  task automatic set_port(int p, bit cs, bit we, bit oe, int ad, int dt);
    cs_n[p] = cs; we_n[p] = we; oe_n[p] = oe;
    addr[p*12 +: 12] = ad[11:0];
    wdata[p*8 +: 8]  = dt[7:0];
  endtask

  // One clock of the reference model: inputs already applied at a falling edge.
  task automatic step(string tag);
    bit   wr [4];
    bit   rd [4];
    int   ad [4];
    int   exp_rd [4];
    bit   exp_mask [4];
    bit   any;
    #1;
    for (int p = 0; p < 4; p++)
      chk("R8", $sformatf("standby[%0d]", p), standby[p], cs_n[p]);
    chk("R8", "all_standby", all_standby, (cs_n == 4'hF));
    for (int p = 0; p < 4; p++) begin
      wr[p] = !cs_n[p] && !we_n[p];
      rd[p] = !cs_n[p] && we_n[p] && !oe_n[p];
      ad[p] = int'(addr[p*12 +: 12]);
    end
    any = 0;
    for (int p = 0; p < 4; p++) begin
      exp_rd[p] = (rd[p] && ref_mem.exists(ad[p])) ? int'(ref_mem[ad[p]]) : 0;
      exp_mask[p] = 0;
      for (int q = 0; q < 4; q++)
        if (q != p && wr[p] && wr[q] && ad[p] == ad[q]) exp_mask[p] = 1;
      any |= exp_mask[p];
    end
    for (int p = 3; p >= 0; p--)
      if (wr[p]) ref_mem[ad[p]] = wdata[p*8 +: 8];
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      chk(tag, $sformatf("rvalid[%0d]", p), rvalid[p], rd[p]);
      chk(tag, $sformatf("rdata[%0d]", p), int'(rdata[p*8 +: 8]), exp_rd[p]);
      chk("R9", $sformatf("coll_mask[%0d]", p), coll_mask[p], exp_mask[p]);
    end
    chk("R9", "coll", coll, any);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle_all();
    set_port(0, 0, 1, 0, 12'h001, 0);
    repeat (3) @(negedge clk);
    // R11: outputs held at zero in reset even with a read requested
    chk("R11", "rvalid in reset", rvalid, 0);
    chk("R11", "rdata in reset", rdata, 0);
    chk("R11", "coll in reset", coll, 0);
    chk("R11", "coll_mask in reset", coll_mask, 0);
    rst_n = 1'b1;
    idle_all();
    step("R11");

    // R3 single write then R1 read-back
    set_port(0, 0, 0, 1, 12'h005, 8'hA5); step("R3");
    idle_all(); set_port(0, 0, 1, 0, 12'h005, 0); step("R1");

    // R1 four distinct writes including both address ends
    idle_all();
    set_port(0, 0, 0, 1, 12'h000, 8'h11);
    set_port(1, 0, 0, 1, 12'hFFF, 8'h22);
    set_port(2, 0, 0, 1, 12'h7A3, 8'h33);
    set_port(3, 0, 0, 1, 12'h800, 8'h44);
    step("R1");
    // R7 rotated cross-port reads
    set_port(0, 0, 1, 0, 12'hFFF, 0);
    set_port(1, 0, 1, 0, 12'h7A3, 0);
    set_port(2, 0, 1, 0, 12'h800, 0);
    set_port(3, 0, 1, 0, 12'h000, 0);
    step("R7");
    set_port(0, 0, 1, 0, 12'h800, 0);
    set_port(1, 0, 1, 0, 12'h000, 0);
    set_port(2, 0, 1, 0, 12'hFFF, 0);
    set_port(3, 0, 1, 0, 12'h7A3, 0);
    step("R7");

    // R6 all four read one word
    for (int p = 0; p < 4; p++) set_port(p, 0, 1, 0, 12'h005, 0);
    step("R6");

    // R4 write with output enabled
    idle_all(); set_port(2, 0, 0, 0, 12'h333, 8'h5C); step("R4");
    idle_all(); set_port(1, 0, 1, 0, 12'h333, 0); step("R4");

    // R2 deselected port with write strobe low must not write
    idle_all(); set_port(1, 1, 0, 0, 12'h333, 8'hEE); step("R2");
    idle_all(); set_port(3, 0, 1, 0, 12'h333, 0); step("R2");

    // R5 output disabled read
    idle_all(); set_port(0, 0, 1, 1, 12'h005, 0); step("R5");

    // R9 three-way collision plus an unrelated writer
    idle_all();
    set_port(0, 0, 0, 1, 12'h010, 8'h01);
    set_port(1, 0, 0, 1, 12'h100, 8'hB1);
    set_port(2, 0, 0, 1, 12'h100, 8'hB2);
    set_port(3, 0, 0, 1, 12'h100, 8'hB3);
    step("R9");
    idle_all(); set_port(0, 0, 1, 0, 12'h100, 0); set_port(1, 0, 1, 0, 12'h010, 0);
    step("R9");
    idle_all(); step("R9");

    // R10 read during another port's write of the same word
    idle_all();
    set_port(0, 0, 0, 1, 12'h005, 8'h6D);
    set_port(2, 0, 1, 0, 12'h005, 0);
    step("R10");
    idle_all(); set_port(2, 0, 1, 0, 12'h005, 0); step("R10");

    // R8 partial and full standby
    idle_all(); set_port(3, 0, 1, 1, 12'h000, 0); step("R8");
    idle_all(); step("R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule